// File: doc/BRIEF.md
# Memory-Operation Issue Queue with Store Ordering

This block holds dispatched memory micro-operations (loads and stores) until their address operands are available. It then hands them to two address pipes, one for loads and one for stores. Each entry records a kind (load or store), an identifier, an age stamp supplied by dispatch, and two address-operand tags with ready bits. A result-tag broadcast sets those ready bits.

Loads are picked out of order: the oldest ready load goes first, even if it was dispatched later than others. A load is held back while any older store remains in the queue. Stores leave strictly by age. A store becomes eligible as soon as its address operands are ready, because store data is not tracked here.

Dispatch is refused while every slot is occupied. A flush carrying an age boundary discards every entry younger than that boundary.

Age stamps are compared modulo 2^AGE_W. Entries in flight must span fewer than 2^(AGE_W-1) stamps, and no two entries in flight may share a stamp.

Top module: `memop_issue_queue`

## Requirements
- R1: After reset the queue is empty: `ld_valid`, `st_valid` and `q_full` are all 0.
- R2: An entry dispatched with both operands ready can issue in the cycle after its dispatch edge. An issued entry leaves the queue at the end of its issue cycle and does not issue again.
- R3: A broadcast on `wk_valid`/`wk_tag` marks every matching operand of a held entry ready from the next cycle on. A broadcast in the same cycle as a dispatch is also captured by the entry being written.
- R4: Loads are not issued in dispatch order. Among eligible loads, the one with the oldest age stamp is issued. Age `a` is older than `b` when bit AGE_W-1 of `a-b` is 1.
- R5: A load is not issued while the queue still holds a store with an older age. This includes a store that issues in that same cycle. A younger store does not hold a load back.
- R6: Stores issue one at a time in age order. A store is eligible once its two address operands are ready.
- R7: At most one load and at most one store issue per cycle, and both may issue in the same cycle.
- R8: `q_full` is 1 exactly while all DEPTH slots are occupied. A dispatch offered while `q_full` is 1 is dropped.
- R9: When `flush_valid` is 1, every entry whose age is younger than `flush_age` is removed at that edge. Entries at or older than the boundary stay. Nothing issues and no dispatch is accepted in a flush cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_store | input | 1 | 1 = store, 0 = load |
| disp_id | input | ID_W | Micro-op identifier returned on issue |
| disp_age | input | AGE_W | Program-order age stamp |
| disp_tag_a | input | TAG_W | Tag of first address operand |
| disp_rdy_a | input | 1 | First address operand already available |
| disp_tag_b | input | TAG_W | Tag of second address operand |
| disp_rdy_b | input | 1 | Second address operand already available |
| q_full | output | 1 | No free slot; dispatch refused |
| wk_valid | input | 1 | Result-tag broadcast valid |
| wk_tag | input | TAG_W | Broadcast tag |
| flush_valid | input | 1 | Flush request |
| flush_age | input | AGE_W | Flush boundary; younger entries are removed |
| ld_valid | output | 1 | A load issues this cycle |
| ld_id | output | ID_W | Identifier of the issuing load |
| st_valid | output | 1 | A store issues this cycle |
| st_id | output | ID_W | Identifier of the issuing store |

## Verification
Every slot field is registered, and issue is decided combinationally from those registers. A dispatch or wakeup presented before edge N is therefore visible on the issue ports in the cycle following edge N, and the issued entry is gone after edge N+1. The bench drives inputs on the falling edge and clears them one falling edge later. It then checks the issue ports immediately, i.e. half a period after the edge that captured the stimulus. Each further expected issue is checked exactly one cycle later, and that repeats until the bench confirms the ports have gone idle.

// File: rtl/miq_pkg.sv
`timescale 1ns/1ps
package miq_pkg;
   typedef enum logic {
      OP_LOAD  = 1'b0,
      OP_STORE = 1'b1
   } miq_op_e;

   localparam int MIQ_MAX_DEPTH = 64;
endpackage

// File: rtl/miq_slot.sv
`timescale 1ns/1ps
module miq_slot #(
   parameter int TAG_W = 6,
   parameter int AGE_W = 8,
   parameter int ID_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc,
   input  logic             kill,
   input  logic             in_store,
   input  logic [ID_W-1:0]  in_id,
   input  logic [AGE_W-1:0] in_age,
   input  logic [TAG_W-1:0] in_tag_a,
   input  logic             in_rdy_a,
   input  logic [TAG_W-1:0] in_tag_b,
   input  logic             in_rdy_b,
   input  logic             wk_valid,
   input  logic [TAG_W-1:0] wk_tag,
   output logic             valid,
   output logic             is_store,
   output logic [ID_W-1:0]  id,
   output logic [AGE_W-1:0] age,
   output logic             ready
);
   import miq_pkg::*;

   miq_op_e          kind_q;
   logic [TAG_W-1:0] tag_a_q, tag_b_q;
   logic             rdy_a_q, rdy_b_q;
   logic             new_hit_a, new_hit_b, old_hit_a, old_hit_b;

   assign new_hit_a = wk_valid && (wk_tag == in_tag_a);
   assign new_hit_b = wk_valid && (wk_tag == in_tag_b);
   assign old_hit_a = wk_valid && (wk_tag == tag_a_q);
   assign old_hit_b = wk_valid && (wk_tag == tag_b_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid   <= 1'b0;
         kind_q  <= OP_LOAD;
         id      <= '0;
         age     <= '0;
         tag_a_q <= '0;
         tag_b_q <= '0;
         rdy_a_q <= 1'b0;
         rdy_b_q <= 1'b0;
      end else if (alloc) begin
         valid   <= 1'b1;
         kind_q  <= in_store ? OP_STORE : OP_LOAD;
         id      <= in_id;
         age     <= in_age;
         tag_a_q <= in_tag_a;
         tag_b_q <= in_tag_b;
         rdy_a_q <= in_rdy_a | new_hit_a;
         rdy_b_q <= in_rdy_b | new_hit_b;
      end else if (kill) begin
         valid <= 1'b0;
      end else if (valid) begin
         if (old_hit_a) rdy_a_q <= 1'b1;
         if (old_hit_b) rdy_b_q <= 1'b1;
      end
   end

   assign is_store = valid && (kind_q == OP_STORE);
   assign ready    = valid && rdy_a_q && rdy_b_q;
endmodule

// File: rtl/miq_alloc.sv
`timescale 1ns/1ps
module miq_alloc #(
   parameter int DEPTH = 16
) (
   input  logic [DEPTH-1:0] busy,
   input  logic             req,
   output logic [DEPTH-1:0] grant,
   output logic             full
);
   logic [DEPTH:0] seen;

   assign seen[0] = 1'b0;
   for (genvar i = 0; i < DEPTH; i++) begin : g_pick
      assign grant[i]  = req && !busy[i] && !seen[i];
      assign seen[i+1] = seen[i] | !busy[i];
   end

   assign full = &busy;
endmodule

// File: rtl/miq_select.sv
`timescale 1ns/1ps
module miq_select #(
   parameter int DEPTH = 16,
   parameter int AGE_W = 8
) (
   input  logic [DEPTH-1:0]            valid,
   input  logic [DEPTH-1:0]            store,
   input  logic [DEPTH-1:0]            ready,
   input  logic [DEPTH-1:0][AGE_W-1:0] age,
   output logic [DEPTH-1:0]            ld_grant,
   output logic [DEPTH-1:0]            st_grant
);
   function automatic logic older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
      logic [AGE_W-1:0] d;
      d = a - b;
      return d[AGE_W-1];
   endfunction

   logic [DEPTH-1:0] st_ahead;
   logic [DEPTH-1:0] ld_elig;

   for (genvar i = 0; i < DEPTH; i++) begin : g_elig
      always_comb begin
         st_ahead[i] = 1'b0;
         for (int j = 0; j < DEPTH; j++) begin
            if (j != i && valid[j] && store[j] && older(age[j], age[i]))
               st_ahead[i] = 1'b1;
         end
      end
      assign ld_elig[i]  = valid[i] && !store[i] && ready[i] && !st_ahead[i];
      assign st_grant[i] = valid[i] &&  store[i] && ready[i] && !st_ahead[i];
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ld_pick
      always_comb begin
         ld_grant[i] = ld_elig[i];
         for (int j = 0; j < DEPTH; j++) begin
            if (j != i && ld_elig[j] && older(age[j], age[i]))
               ld_grant[i] = 1'b0;
         end
      end
   end
endmodule

// File: rtl/memop_issue_queue.sv
`timescale 1ns/1ps
module memop_issue_queue #(
   parameter int DEPTH = 16,
   parameter int TAG_W = 6,
   parameter int AGE_W = 8,
   parameter int ID_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             disp_valid,
   input  logic             disp_store,
   input  logic [ID_W-1:0]  disp_id,
   input  logic [AGE_W-1:0] disp_age,
   input  logic [TAG_W-1:0] disp_tag_a,
   input  logic             disp_rdy_a,
   input  logic [TAG_W-1:0] disp_tag_b,
   input  logic             disp_rdy_b,
   output logic             q_full,
   input  logic             wk_valid,
   input  logic [TAG_W-1:0] wk_tag,
   input  logic             flush_valid,
   input  logic [AGE_W-1:0] flush_age,
   output logic             ld_valid,
   output logic [ID_W-1:0]  ld_id,
   output logic             st_valid,
   output logic [ID_W-1:0]  st_id
);
   localparam int IDX_W = $clog2(DEPTH);

   if (DEPTH < 2 || DEPTH > miq_pkg::MIQ_MAX_DEPTH) begin : g_bad_depth
      $error("memop_issue_queue: DEPTH out of range");
   end
   if (AGE_W < IDX_W + 2) begin : g_bad_age
      $error("memop_issue_queue: AGE_W too narrow for DEPTH");
   end
   if (TAG_W < 1 || ID_W < 1) begin : g_bad_width
      $error("memop_issue_queue: tag and id widths must be positive");
   end

   function automatic logic older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
      logic [AGE_W-1:0] d;
      d = a - b;
      return d[AGE_W-1];
   endfunction

   logic [DEPTH-1:0]            slot_valid, slot_store, slot_ready, slot_kill;
   logic [DEPTH-1:0]            alloc_vec, ld_grant, st_grant, ld_take, st_take;
   logic [DEPTH-1:0][AGE_W-1:0] slot_age;
   logic [DEPTH-1:0][ID_W-1:0]  slot_id;
   logic                        alloc_req;

   assign alloc_req = disp_valid && !flush_valid;

   miq_alloc #(.DEPTH(DEPTH)) u_alloc (
      .busy  (slot_valid),
      .req   (alloc_req),
      .grant (alloc_vec),
      .full  (q_full)
   );

   miq_select #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_select (
      .valid    (slot_valid),
      .store    (slot_store),
      .ready    (slot_ready),
      .age      (slot_age),
      .ld_grant (ld_grant),
      .st_grant (st_grant)
   );

   assign ld_take = flush_valid ? '0 : ld_grant;
   assign st_take = flush_valid ? '0 : st_grant;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign slot_kill[i] = ld_take[i] || st_take[i] ||
                            (flush_valid && slot_valid[i] && older(flush_age, slot_age[i]));
      miq_slot #(.TAG_W(TAG_W), .AGE_W(AGE_W), .ID_W(ID_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .alloc    (alloc_vec[i]),
         .kill     (slot_kill[i]),
         .in_store (disp_store),
         .in_id    (disp_id),
         .in_age   (disp_age),
         .in_tag_a (disp_tag_a),
         .in_rdy_a (disp_rdy_a),
         .in_tag_b (disp_tag_b),
         .in_rdy_b (disp_rdy_b),
         .wk_valid (wk_valid),
         .wk_tag   (wk_tag),
         .valid    (slot_valid[i]),
         .is_store (slot_store[i]),
         .id       (slot_id[i]),
         .age      (slot_age[i]),
         .ready    (slot_ready[i])
      );
   end

   always_comb begin
      ld_id = '0;
      st_id = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (ld_take[i]) ld_id = ld_id | slot_id[i];
         if (st_take[i]) st_id = st_id | slot_id[i];
      end
   end

   assign ld_valid = |ld_take;
   assign st_valid = |st_take;
endmodule

// File: rtl/memop_issue_queue_chk.sv
`timescale 1ns/1ps
module memop_issue_queue_chk #(
   parameter int DEPTH = 16,
   parameter int AGE_W = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        flush_valid,
   input logic                        ld_valid,
   input logic                        st_valid,
   input logic [DEPTH-1:0]            ld_take,
   input logic [DEPTH-1:0]            st_take,
   input logic [DEPTH-1:0]            alloc_vec,
   input logic [DEPTH-1:0]            slot_valid,
   input logic [DEPTH-1:0]            slot_store,
   input logic [DEPTH-1:0][AGE_W-1:0] slot_age
);
   function automatic logic older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
      logic [AGE_W-1:0] d;
      d = a - b;
      return d[AGE_W-1];
   endfunction

   logic ld_pass_store, st_pass_store;
   always_comb begin
      ld_pass_store = 1'b0;
      st_pass_store = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         for (int j = 0; j < DEPTH; j++) begin
            if (slot_valid[j] && slot_store[j] && older(slot_age[j], slot_age[i])) begin
               if (ld_take[i]) ld_pass_store = 1'b1;
               if (st_take[i]) st_pass_store = 1'b1;
            end
         end
      end
   end

   p_one_load_r7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ld_take));
   p_one_store_r7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(st_take));
   p_ld_behind_store_r5: assert property (@(posedge clk) disable iff (!rst_n) !ld_pass_store);
   p_st_in_order_r6: assert property (@(posedge clk) disable iff (!rst_n) !st_pass_store);
   p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |-> !ld_valid && !st_valid);
   p_issue_leaves_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ld_take | st_take)) |=> ((slot_valid & $past(ld_take | st_take)) == '0));
   p_alloc_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(alloc_vec) && ((alloc_vec & slot_valid) == '0));
endmodule

bind memop_issue_queue memop_issue_queue_chk #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flush_valid (flush_valid),
   .ld_valid    (ld_valid),
   .st_valid    (st_valid),
   .ld_take     (ld_take),
   .st_take     (st_take),
   .alloc_vec   (alloc_vec),
   .slot_valid  (slot_valid),
   .slot_store  (slot_store),
   .slot_age    (slot_age)
);

// File: tb/sim_memop_issue_queue.sv
`timescale 1ns/1ps
module sim_memop_issue_queue;
   localparam int DEPTH = 16;
   localparam int TAG_W = 6;
   localparam int AGE_W = 8;
   localparam int ID_W  = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             disp_valid = 1'b0, disp_store = 1'b0;
   logic [ID_W-1:0]  disp_id = '0;
   logic [AGE_W-1:0] disp_age = '0;
   logic [TAG_W-1:0] disp_tag_a = '0, disp_tag_b = '0;
   logic             disp_rdy_a = 1'b0, disp_rdy_b = 1'b0;
   logic             q_full;
   logic             wk_valid = 1'b0;
   logic [TAG_W-1:0] wk_tag = '0;
   logic             flush_valid = 1'b0;
   logic [AGE_W-1:0] flush_age = '0;
   logic             ld_valid, st_valid;
   logic [ID_W-1:0]  ld_id, st_id;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   memop_issue_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .AGE_W(AGE_W), .ID_W(ID_W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_store(disp_store), .disp_id(disp_id), .disp_age(disp_age),
      .disp_tag_a(disp_tag_a), .disp_rdy_a(disp_rdy_a), .disp_tag_b(disp_tag_b), .disp_rdy_b(disp_rdy_b),
      .q_full(q_full), .wk_valid(wk_valid), .wk_tag(wk_tag),
      .flush_valid(flush_valid), .flush_age(flush_age),
      .ld_valid(ld_valid), .ld_id(ld_id), .st_valid(st_valid), .st_id(st_id)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic expect_ld(input string req, input int id);
      check(ld_valid == 1'b1 && int'(ld_id) == id, req, ld_valid ? int'(ld_id) : -1, id);
   endtask

   task automatic expect_st(input string req, input int id);
      check(st_valid == 1'b1 && int'(st_id) == id, req, st_valid ? int'(st_id) : -1, id);
   endtask

   task automatic expect_idle(input string req);
      check(!ld_valid && !st_valid, req, {ld_valid, st_valid}, 0);
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   // offer one entry, optionally with a broadcast in the same cycle; id equals age
   task automatic disp(input bit st, input int age, input int tag, input bit rdy,
                       input bit wk = 1'b0, input int wtag = 0);
      disp_valid = 1'b1; disp_store = st;
      disp_id = ID_W'(age); disp_age = AGE_W'(age);
      disp_tag_a = TAG_W'(tag); disp_rdy_a = rdy;
      disp_tag_b = '0; disp_rdy_b = 1'b1;
      wk_valid = wk; wk_tag = TAG_W'(wtag);
      cyc();
      disp_valid = 1'b0; wk_valid = 1'b0;
   endtask

   task automatic wake(input int tag);
      wk_valid = 1'b1; wk_tag = TAG_W'(tag);
      cyc();
      wk_valid = 1'b0;
   endtask

   task automatic t_reset();
      check(!ld_valid && !st_valid && !q_full, "R1", {ld_valid, st_valid, q_full}, 0);
   endtask

   task automatic t_ready_issue();
      disp(1'b0, 1, 0, 1'b1);
      expect_ld("R2", 1);
      cyc();
      expect_idle("R2");
   endtask

   task automatic t_wakeup();
      disp(1'b0, 2, 5, 1'b0);
      expect_idle("R3");
      wake(5);
      expect_ld("R3", 2);
      cyc();
      disp(1'b0, 3, 7, 1'b0, 1'b1, 7);
      expect_ld("R3", 3);
      cyc();
      expect_idle("R3");
   endtask

   task automatic t_load_order();
      disp(1'b0, 10, 3, 1'b0);
      disp(1'b0, 11, 0, 1'b1);
      expect_ld("R4", 11);
      wake(3);
      expect_ld("R4", 10);
      cyc();
      disp(1'b0, 21, 4, 1'b0);
      disp(1'b0, 20, 4, 1'b0);
      wake(4);
      expect_ld("R4", 20);
      cyc();
      expect_ld("R4", 21);
      cyc();
      expect_idle("R4");
   endtask

   task automatic t_store_blocks();
      disp(1'b1, 30, 8, 1'b0);
      disp(1'b0, 31, 0, 1'b1);
      expect_idle("R5");
      wake(8);
      expect_st("R5", 30);
      check(!ld_valid, "R5", ld_valid, 0);
      cyc();
      expect_ld("R5", 31);
      cyc();
      disp(1'b1, 41, 9, 1'b0);
      disp(1'b0, 40, 0, 1'b1);
      expect_ld("R5", 40);
      wake(9);
      expect_st("R5", 41);
      cyc();
      expect_idle("R5");
   endtask

   task automatic t_store_order();
      disp(1'b1, 50, 10, 1'b0);
      disp(1'b1, 51, 0, 1'b1);
      expect_idle("R6");
      wake(10);
      expect_st("R6", 50);
      cyc();
      expect_st("R6", 51);
      cyc();
      expect_idle("R6");
   endtask

   task automatic t_dual_issue();
      disp(1'b0, 59, 11, 1'b0);
      disp(1'b1, 60, 11, 1'b0);
      wake(11);
      expect_ld("R7", 59);
      expect_st("R7", 60);
      cyc();
      expect_idle("R7");
   endtask

   task automatic t_full_flush();
      for (int k = 0; k < DEPTH; k++) begin
         check(!q_full, "R8", q_full, 0);
         disp(1'b0, 70 + k, 12, 1'b0);
      end
      check(q_full, "R8", q_full, 1);
      disp(1'b0, 90, 0, 1'b1);
      expect_idle("R8");
      flush_valid = 1'b1; flush_age = AGE_W'(77);
      cyc();
      flush_valid = 1'b0;
      check(!q_full, "R9", q_full, 0);
      wake(12);
      for (int k = 0; k < 8; k++) begin
         expect_ld("R9", 70 + k);
         cyc();
      end
      expect_idle("R9");
   endtask

   initial begin
      repeat (3) cyc();
      t_reset();
      rst_n = 1'b1;
      cyc();
      t_reset();
      t_ready_issue();
      t_wakeup();
      t_load_order();
      t_store_blocks();
      t_store_order();
      t_dual_issue();
      t_full_flush();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule